// File: doc/BRIEF.md
# Paged Boot ROM Memory Decoder

This block is the address-decode glue for an 8-bit processor with a 16-bit address bus. On each bus cycle it picks one target: a 4 KB window of a 32 KB boot ROM, a RAM that covers the whole 64 KB space, or one of four registers in a small I/O block. The I/O block holds the serial port's data and command registers, a board status register that can be read, and a board control register that software writes. The chip selects follow the address and strobes combinationally, so they are valid in the same cycle as the access. The only clocked state is the control register.

Straps set where the ROM window sits, where the I/O block sits, whether ROM writes are blocked, and the reset values of two flags. The ROM-enable flag lets the ROM window answer. The boot flag adds a second copy of the ROM window at the bottom of memory, so the processor can fetch its reset vector from ROM. Three control bits pick which 4 KB page of the ROM device the window shows. Software can clear either flag by writing the control register. Only a reset sets them again.

Top module: `pagedRomDecoder`

## Requirements
- R1: After reset the page bits are 0, the ROM-enable flag equals `romEnStrap` and the boot flag equals `bootStrap`.
- R2: While ROM is enabled, a memory cycle with A[15:12] equal to `romBaseStrap` asserts `romCs`, deasserts `ramCs`, and drives `romAddr` = {page, A[11:0]}.
- R3: While both flags are set, a memory cycle with A[15:12] = 0 also selects ROM in the same way, with the current page.
- R4: While the ROM-enable flag is clear, no memory cycle selects ROM. This includes the bottom window, whatever the boot flag is.
- R5: Every memory read or write that does not select ROM asserts `ramCs`.
- R6: A write that selects ROM pulses `romWe` only while `romWpStrap` is 0. `romCs` does not depend on the strap.
- R7: An I/O cycle to a port whose bits [7:2] equal `ioBaseStrap` is a block hit. Offsets 0 and 1 assert `usartCs`, and `usartCd` carries port bit 0.
- R8: An I/O read at offset 2 asserts `statusOe` and puts on `dataOut` bits [2:0] page, bit 3 ROM-enable, bit 4 boot, and 0 in bits [7:5]. At every other time `dataOut` is 0.
- R9: An I/O write at offset 3 loads the page from data bits [2:0]. Data bit 3 = 1 clears the ROM-enable flag and data bit 4 = 1 clears the boot flag. A 0 in either bit leaves that flag unchanged.
- R10: Once cleared, a flag stays clear until the next reset, whatever is written.
- R11: I/O cycles never select ROM or RAM, and memory cycles never select an I/O register. I/O cycles outside the block, and block writes at offsets other than 3, leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address; the port number is in bits [7:0] |
| dataIn | input | 8 | Processor write data |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| ioCycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| romEnStrap | input | 1 | Reset value of the ROM-enable flag |
| bootStrap | input | 1 | Reset value of the boot flag |
| romWpStrap | input | 1 | 1 blocks ROM write strobes |
| romBaseStrap | input | 4 | A[15:12] of the ROM window |
| ioBaseStrap | input | 6 | Port bits [7:2] of the I/O block |
| romCs | output | 1 | ROM chip select |
| romWe | output | 1 | ROM write strobe |
| romAddr | output | 15 | ROM device address |
| ramCs | output | 1 | RAM chip select |
| usartCs | output | 1 | Serial port chip select |
| usartCd | output | 1 | Serial port command/data select |
| statusOe | output | 1 | Status register is driving the data bus |
| dataOut | output | 8 | Status read data |

## Verification
The assertions check on every cycle that ROM and RAM are never selected together, that I/O cycles select no memory, that the write-protect strap blocks `romWe`, that a cleared ROM-enable flag removes every ROM select, that the page follows the last control write, and that neither flag ever rises without a reset. Only the bench scenarios can show where the window lands for each base strap, that the bottom-window overlay depends on both flags, the exact status bit layout, and that I/O accesses outside the block or at the wrong offset leave the state alone. To cover these, the bench sweeps all address nibbles, every base strap and every port number.

// File: rtl/romdec_pkg.sv
package romdec_pkg;
  localparam int CTL_ROMOFF_BIT  = 3;
  localparam int CTL_BOOTOFF_BIT = 4;
  localparam logic [1:0] OFS_STATUS = 2'd2;
  localparam logic [1:0] OFS_CTRL   = 2'd3;

  typedef struct packed {
    logic romSel;
    logic romWr;
    logic ramSel;
    logic usartSel;
    logic statRd;
    logic ctrlWr;
  } decStrobe_t;
endpackage

// File: rtl/romdec_ctrl.sv
module romdec_ctrl
  import romdec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 12,
  parameter int IO_PORT_W = 8,
  parameter int IO_BLK_W  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic busRd,
  input  logic busWr,
  input  logic ioCycle,
  input  logic romEn,
  input  logic bootMap,
  input  logic romWpStrap,
  input  logic [ADDR_W-PAGE_W-1:0] romBaseStrap,
  input  logic [IO_PORT_W-IO_BLK_W-1:0] ioBaseStrap,
  output decStrobe_t stb
);
  localparam int WIN_W = ADDR_W - PAGE_W;

  logic [WIN_W-1:0] winNib;
  logic memAccess, ioAccess, romHit, blockHit;
  logic [IO_BLK_W-1:0] ioOfs;

  assign winNib    = addr[ADDR_W-1:PAGE_W];
  assign memAccess = !ioCycle && (busRd || busWr);
  assign ioAccess  = ioCycle && (busRd || busWr);
  assign ioOfs     = addr[IO_BLK_W-1:0];

  always_comb begin
    romHit = 1'b0;
    if (romEn) begin
      if (winNib == romBaseStrap) romHit = 1'b1;
      if (bootMap && winNib == '0) romHit = 1'b1;
    end
    blockHit = ioAccess && (addr[IO_PORT_W-1:IO_BLK_W] == ioBaseStrap);
  end

  always_comb begin
    stb = '0;
    stb.romSel    = memAccess && romHit;
    stb.romWr     = memAccess && romHit && busWr && !romWpStrap;
    stb.ramSel    = memAccess && !romHit;
    stb.usartSel  = blockHit && !ioOfs[1];
    stb.statRd    = blockHit && busRd && (ioOfs == OFS_STATUS);
    stb.ctrlWr    = blockHit && busWr && (ioOfs == OFS_CTRL);
  end

  a_r5_rom_ram_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.romSel && stb.ramSel));
  a_r11_io_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    ioCycle |-> !stb.romSel && !stb.ramSel);
  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rstN)
    romWpStrap |-> !stb.romWr);
  a_r4_rom_off: assert property (@(posedge clk) disable iff (!rstN)
    !romEn |-> !stb.romSel);
  a_r11_mem_no_io: assert property (@(posedge clk) disable iff (!rstN)
    !ioCycle |-> !stb.usartSel && !stb.statRd && !stb.ctrlWr);
endmodule

// File: rtl/romdec_datapath.sv
module romdec_datapath
  import romdec_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 12,
  parameter int PAGESEL_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  decStrobe_t stb,
  input  logic [CTL_BOOTOFF_BIT:0] ctrlData,
  input  logic [PAGE_W-1:0] winOfs,
  input  logic romEnStrap,
  input  logic bootStrap,
  output logic romEn,
  output logic bootMap,
  output logic [PAGESEL_W+PAGE_W-1:0] romAddr,
  output logic [DATA_W-1:0] dataOut
);
  logic [PAGESEL_W-1:0] pageQ;
  logic romEnQ, bootQ;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ  <= '0;
      romEnQ <= romEnStrap;
      bootQ  <= bootStrap;
    end else if (stb.ctrlWr) begin
      pageQ <= ctrlData[PAGESEL_W-1:0];
      if (ctrlData[CTL_ROMOFF_BIT])  romEnQ <= 1'b0;
      if (ctrlData[CTL_BOOTOFF_BIT]) bootQ  <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[PAGESEL_W-1:0]  = pageQ;
    statusWord[CTL_ROMOFF_BIT]  = romEnQ;
    statusWord[CTL_BOOTOFF_BIT] = bootQ;
  end

  assign romEn   = romEnQ;
  assign bootMap = bootQ;
  assign romAddr = {pageQ, winOfs};
  assign dataOut = stb.statRd ? statusWord : '0;

  a_r9_page_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlWr |=> pageQ == $past(ctrlData[PAGESEL_W-1:0]));
  a_r10_romen_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !romEnQ |=> !romEnQ);
  a_r10_boot_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !bootQ |=> !bootQ);
  a_r11_page_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctrlWr |=> $stable(pageQ));
endmodule

// File: rtl/pagedRomDecoder.sv
module pagedRomDecoder
  import romdec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 12,
  parameter int PAGESEL_W = 3,
  parameter int IO_PORT_W = 8,
  parameter int IO_BLK_W  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic busRd,
  input  logic busWr,
  input  logic ioCycle,
  input  logic romEnStrap,
  input  logic bootStrap,
  input  logic romWpStrap,
  input  logic [ADDR_W-PAGE_W-1:0] romBaseStrap,
  input  logic [IO_PORT_W-IO_BLK_W-1:0] ioBaseStrap,
  output logic romCs,
  output logic romWe,
  output logic [PAGESEL_W+PAGE_W-1:0] romAddr,
  output logic ramCs,
  output logic usartCs,
  output logic usartCd,
  output logic statusOe,
  output logic [DATA_W-1:0] dataOut
);
  decStrobe_t stb;
  logic romEn, bootMap;
  logic unusedHiData;

  assign unusedHiData = ^dataIn[DATA_W-1:CTL_BOOTOFF_BIT+1];

  romdec_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IO_PORT_W(IO_PORT_W), .IO_BLK_W(IO_BLK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .busRd(busRd), .busWr(busWr),
    .ioCycle(ioCycle), .romEn(romEn), .bootMap(bootMap),
    .romWpStrap(romWpStrap), .romBaseStrap(romBaseStrap),
    .ioBaseStrap(ioBaseStrap), .stb(stb)
  );

  romdec_datapath #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PAGESEL_W(PAGESEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .ctrlData(dataIn[CTL_BOOTOFF_BIT:0]), .winOfs(addr[PAGE_W-1:0]),
    .romEnStrap(romEnStrap), .bootStrap(bootStrap),
    .romEn(romEn), .bootMap(bootMap), .romAddr(romAddr), .dataOut(dataOut)
  );

  assign romCs    = stb.romSel;
  assign romWe    = stb.romWr;
  assign ramCs    = stb.ramSel;
  assign usartCs  = stb.usartSel;
  assign usartCd  = addr[0];
  assign statusOe = stb.statRd;
endmodule

// File: tb/test_pagedRomDecoder.sv
module test_pagedRomDecoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic busRd = 1'b0, busWr = 1'b0, ioCycle = 1'b0;
  logic romEnStrap = 1'b1, bootStrap = 1'b1, romWpStrap = 1'b0;
  logic [3:0] romBaseStrap = 4'hF;
  logic [5:0] ioBaseStrap = '0;
  logic romCs, romWe, ramCs, usartCs, usartCd, statusOe;
  logic [14:0] romAddr;
  logic [7:0] dataOut;

  int nChecks = 0;
  int nFail = 0;
  logic [2:0] mPage;
  logic mRomEn, mBoot;

  always #10 clk = ~clk;

  pagedRomDecoder i_pagedRomDecoder (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .busRd(busRd),
    .busWr(busWr), .ioCycle(ioCycle), .romEnStrap(romEnStrap),
    .bootStrap(bootStrap), .romWpStrap(romWpStrap), .romBaseStrap(romBaseStrap),
    .ioBaseStrap(ioBaseStrap), .romCs(romCs), .romWe(romWe), .romAddr(romAddr),
    .ramCs(ramCs), .usartCs(usartCs), .usartCd(usartCd), .statusOe(statusOe),
    .dataOut(dataOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus();
    return {3'b000, mBoot, mRomEn, mPage};
  endfunction

  task automatic doReset(input logic en, input logic bt, input logic wp,
                         input logic [3:0] base, input logic [5:0] io);
    @(negedge clk);
    rstN = 1'b0;
    romEnStrap = en; bootStrap = bt; romWpStrap = wp;
    romBaseStrap = base; ioBaseStrap = io;
    busRd = 0; busWr = 0; ioCycle = 0;
    @(negedge clk);
    rstN = 1'b1;
    mPage = '0; mRomEn = en; mBoot = bt;
  endtask

  task automatic readStatus(input string req);
    @(negedge clk);
    addr = {8'h00, ioBaseStrap, 2'b10};
    ioCycle = 1; busRd = 1; busWr = 0;
    #5;
    chk(statusOe === 1'b1, req, statusOe, 1);
    chk(dataOut === expStatus(), req, dataOut, expStatus());
    @(negedge clk);
    busRd = 0; ioCycle = 0;
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk);
    addr = {8'h00, ioBaseStrap, 2'b11};
    ioCycle = 1; busWr = 1; busRd = 0; dataIn = v;
    @(negedge clk);
    busWr = 0; ioCycle = 0;
    mPage = v[2:0];
    if (v[3]) mRomEn = 1'b0;
    if (v[4]) mBoot = 1'b0;
  endtask

  task automatic memSweep();
    logic [11:0] ofsList [3];
    ofsList[0] = 12'h000; ofsList[1] = 12'hA5C; ofsList[2] = 12'hFFF;
    for (int nib = 0; nib < 16; nib++) begin
      for (int k = 0; k < 3; k++) begin
        for (int w = 0; w < 2; w++) begin
          logic hit;
          string req;
          @(negedge clk);
          addr = {nib[3:0], ofsList[k]};
          ioCycle = 0; busRd = (w == 0); busWr = (w == 1); dataIn = 8'hFF;
          #5;
          hit = mRomEn && (nib[3:0] == romBaseStrap || (mBoot && nib == 0));
          if (!mRomEn) req = "R4 rom select";
          else if (nib[3:0] == romBaseStrap) req = "R2 rom select";
          else if (nib == 0) req = "R3 rom select";
          else req = "R5 rom select";
          chk(romCs === hit, req, romCs, hit);
          chk(ramCs === !hit, "R5 ram select", ramCs, !hit);
          chk(romWe === (hit && w == 1 && !romWpStrap), "R6 rom write strobe",
              romWe, hit && w == 1 && !romWpStrap);
          if (hit) chk(romAddr === {mPage, ofsList[k]}, "R2 rom address",
                       romAddr, {mPage, ofsList[k]});
          chk(usartCs === 1'b0 && statusOe === 1'b0, "R11 no io on mem",
              {usartCs, statusOe}, 0);
        end
      end
    end
    @(negedge clk);
    busRd = 0; busWr = 0;
  endtask

  task automatic ioSweep();
    for (int p = 0; p < 256; p++) begin
      for (int w = 0; w < 2; w++) begin
        logic blk, us, so;
        logic [7:0] expD;
        if (w == 1 && p[7:2] == ioBaseStrap && p[1:0] == 2'b11) continue;
        @(negedge clk);
        addr = {8'hF0, p[7:0]};
        ioCycle = 1; busRd = (w == 0); busWr = (w == 1); dataIn = 8'hFF;
        #5;
        blk = (p[7:2] == ioBaseStrap);
        us = blk && !p[1];
        so = blk && w == 0 && p[1:0] == 2'b10;
        expD = so ? expStatus() : 8'h00;
        chk(usartCs === us, "R7 usart select", usartCs, us);
        if (us) chk(usartCd === p[0], "R7 usart cmd/data", usartCd, p[0]);
        chk(statusOe === so, "R8 status enable", statusOe, so);
        chk(dataOut === expD, "R8 data out", dataOut, expD);
        chk(romCs === 1'b0 && ramCs === 1'b0, "R11 no mem on io",
            {romCs, ramCs}, 0);
      end
    end
    @(negedge clk);
    busRd = 0; busWr = 0; ioCycle = 0;
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: default straps
    doReset(1'b1, 1'b1, 1'b0, 4'hF, 6'h00);
    readStatus("R1 reset status");
    memSweep();
    // R9: page select, flags untouched by zero bits
    writeCtrl(8'h05);
    readStatus("R9 page load");
    memSweep();
    writeCtrl(8'hE2);
    readStatus("R9 high bits ignored");
    // R9: clear boot flag only
    writeCtrl(8'h13);
    readStatus("R9 boot clear");
    memSweep();
    // R10: flags cannot be set again by writing
    writeCtrl(8'h06);
    readStatus("R10 boot stays clear");
    writeCtrl(8'h08);
    readStatus("R9 romen clear");
    memSweep();
    writeCtrl(8'h01);
    readStatus("R10 romen stays clear");
    // R4: ROM disabled at reset, boot strap set
    doReset(1'b0, 1'b1, 1'b0, 4'hF, 6'h00);
    readStatus("R1 strap reset values");
    memSweep();
    // R6: write protect with a low window
    doReset(1'b1, 1'b1, 1'b1, 4'h3, 6'h00);
    writeCtrl(8'h07);
    memSweep();
    // R2: every window base, with and without overlay
    for (int b = 0; b < 16; b++) begin
      doReset(1'b1, b[0], 1'b0, b[3:0], 6'h00);
      writeCtrl({5'b0, b[2:0]});
      memSweep();
    end
    // R7, R8, R11: I/O decode over all ports at two bases
    doReset(1'b1, 1'b1, 1'b0, 4'hF, 6'h00);
    writeCtrl(8'h04);
    ioSweep();
    readStatus("R11 state unchanged");
    doReset(1'b1, 1'b0, 1'b0, 4'hF, 6'h2A);
    writeCtrl(8'h03);
    ioSweep();
    readStatus("R11 state unchanged");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule